// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps SDRAM contents alive. A free-running interval timer schedules one auto-refresh every `REFI_CYC = CLK_KHZ * REF_WINDOW_MS / REF_ROWS` clock cycles. `REF_ROWS` refreshes therefore fall inside each retention window. Each scheduled refresh becomes a pending credit, and while credit exists the block raises `ref_req` toward the main memory controller. Once the controller has closed every bank and asserts `grant`, the sequencer takes the command pins, indicated by `busy`. It then issues the refresh and holds the bus on NOPs until the refresh cycle and precharge times have both passed.

For low-power retention the controller raises `sr_req` together with `grant`. The sequencer then issues a full burst of `REF_ROWS` refreshes, spaced at the minimum legal interval, and afterwards issues the refresh encoding with clock enable driven low. That command enters self-refresh. Clock enable stays low for as long as needed. A pulse on `sr_exit` raises clock enable, keeps the bus on NOPs for the exit recovery time, runs a second full burst, and then returns the bus to the controller.

Top module: `sdr_refresh_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, the outputs are `cke`=1, command NOP ({ras_n,cas_n,we_n}=3'b111), `busy`=0 and `ref_req`=0.
- R2: Every `REFI_CYC` cycles the timer adds one pending refresh, saturating at `PEND_MAX`. `ref_req` is high whenever the bus is free and a refresh is pending or `sr_req` is high.
- R3: A refresh starts only if `grant` and `banks_idle` were both high in the preceding cycle. The refresh command is {ras_n,cas_n,we_n}=3'b001 with `cke`=1, and `busy` rises with it.
- R4: After any refresh command, whether auto or self-refresh entry, the next command other than NOP comes no earlier than G = max(T_RC, T_RP) cycles later.
- R5: A single periodic refresh holds `busy` high for exactly G cycles and consumes one pending credit.
- R6: A granted `sr_req` (priority over a single refresh) produces exactly `REF_ROWS` refreshes with `cke`=1, each G cycles apart. G cycles after the last of them comes command 3'b001 with `cke`=0.
- R7: In self-refresh `cke` stays low and the command stays NOP for any duration. `sr_req`, `grant` and `banks_idle` have no effect there.
- R8: An `sr_exit` pulse in self-refresh raises `cke` in the next cycle. The first refresh follows exactly T_XSR cycles after that rise. A burst of `REF_ROWS` refreshes follows, `busy` falls G cycles after the last one, and the pending credit is cleared.
- R9: `busy` is high whenever the command is not NOP or `cke` is low.
- R10: `sr_exit` outside self-refresh has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All banks are precharged |
| grant | input | 1 | Controller hands the command bus to the sequencer |
| sr_req | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Pulse to leave self-refresh |
| ref_req | output | 1 | Sequencer wants the bus |
| busy | output | 1 | Sequencer owns the command bus |
| cke | output | 1 | SDRAM clock enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bound checker watches the timing rules on every cycle. It checks the G-cycle spacing after each refresh and the T_XSR quiet period after clock enable rises. It also checks that clock enable only falls with the refresh encoding, that the bus carries NOPs while self-refresh lasts, that `busy` covers every command and every low clock enable, and that ownership begins only after a grant with idle banks. Other properties only the bench scenarios can show: the refresh count per retention window, saturation of pending credit while the grant is withheld, the exact burst lengths on either side of self-refresh, the measured exit delay, and that `sr_exit` has no effect during normal running.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_GAP   = 2'd1,
    ST_BURST = 2'd2,
    ST_SELF  = 2'd3
  } seq_state_t;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_REF = 3'b001;
endpackage

// File: rtl/ref_interval.sv
module ref_interval #(
  parameter int PERIOD = 1953
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q;
  logic         last;

  assign last = (cnt_q == W'(PERIOD - 1));
  assign tick = last;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_downcnt.sv
module ref_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (dec && !zero)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdr_refresh_seq.sv
module sdr_refresh_seq
  import sdr_ref_pkg::*;
#(
  parameter int CLK_KHZ       = 125000,
  parameter int REF_WINDOW_MS = 64,
  parameter int REF_ROWS      = 4096,
  parameter int T_RC          = 8,
  parameter int T_RP          = 3,
  parameter int T_XSR         = 10,
  parameter int PEND_MAX      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic banks_idle,
  input  logic grant,
  input  logic sr_req,
  input  logic sr_exit,
  output logic ref_req,
  output logic busy,
  output logic cke,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int REFI_CYC = CLK_KHZ * REF_WINDOW_MS / REF_ROWS;
  localparam int GAP      = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int TMAX     = (GAP > T_XSR) ? GAP : T_XSR;
  localparam int GW       = $clog2(TMAX + 1);
  localparam int BW       = $clog2(REF_ROWS + 1);
  localparam int PW       = $clog2(PEND_MAX + 1);

  seq_state_t st_q, st_n;
  logic [PW-1:0] pend_q, pend_n;
  logic [PW:0]   pend_sum;
  logic          post_q, post_n;
  logic [2:0]    cmd_q, cmd_n;
  logic          cke_q, cke_n;
  logic          busy_q, req_q;
  logic          tick, pend_dec;
  logic          gap_load, gap_dec, gap_zero;
  logic [GW-1:0] gap_val;
  logic          left_load, left_dec, left_zero;
  logic [BW-1:0] left_val;

  ref_interval #(.PERIOD(REFI_CYC)) u_interval (
    .clk (clk), .rst (rst), .tick (tick)
  );

  ref_downcnt #(.W(GW)) u_gap (
    .clk (clk), .rst (rst), .load (gap_load), .load_val (gap_val),
    .dec (gap_dec), .zero (gap_zero)
  );

  ref_downcnt #(.W(BW)) u_left (
    .clk (clk), .rst (rst), .load (left_load), .load_val (left_val),
    .dec (left_dec), .zero (left_zero)
  );

  always_comb begin
    st_n      = st_q;
    post_n    = post_q;
    cmd_n     = CMD_NOP;
    cke_n     = cke_q;
    gap_load  = 1'b0;
    gap_val   = GW'(GAP - 1);
    gap_dec   = 1'b0;
    left_load = 1'b0;
    left_val  = BW'(REF_ROWS - 1);
    left_dec  = 1'b0;
    pend_dec  = 1'b0;
    case (st_q)
      ST_RUN: begin
        cke_n = 1'b1;
        if (grant && banks_idle && (sr_req || pend_q != '0)) begin
          cmd_n    = CMD_REF;
          gap_load = 1'b1;
          if (sr_req) begin
            st_n      = ST_BURST;
            post_n    = 1'b0;
            left_load = 1'b1;
          end else begin
            st_n     = ST_GAP;
            pend_dec = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gap_zero) st_n = ST_RUN;
        else          gap_dec = 1'b1;
      end
      ST_BURST: begin
        if (!gap_zero) begin
          gap_dec = 1'b1;
        end else if (!left_zero) begin
          cmd_n    = CMD_REF;
          left_dec = 1'b1;
          gap_load = 1'b1;
        end else if (!post_q) begin
          cmd_n = CMD_REF;
          cke_n = 1'b0;
          st_n  = ST_SELF;
        end else begin
          st_n = ST_RUN;
        end
      end
      ST_SELF: begin
        cke_n = 1'b0;
        if (sr_exit) begin
          cke_n     = 1'b1;
          gap_load  = 1'b1;
          gap_val   = GW'(T_XSR - 1);
          left_load = 1'b1;
          left_val  = BW'(REF_ROWS);
          post_n    = 1'b1;
          st_n      = ST_BURST;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_comb begin
    pend_sum = {1'b0, pend_q} + (PW+1)'(tick) - (PW+1)'(pend_dec);
    if (st_q == ST_BURST || st_q == ST_SELF) pend_n = '0;
    else if (pend_sum > (PW+1)'(PEND_MAX))   pend_n = PW'(PEND_MAX);
    else                                     pend_n = pend_sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      pend_q <= '0;
      post_q <= 1'b0;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b1;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      post_q <= post_n;
      cmd_q  <= cmd_n;
      cke_q  <= cke_n;
      busy_q <= (st_n != ST_RUN);
      req_q  <= (st_n == ST_RUN) && (sr_req || pend_n != '0);
    end
  end

  assign ras_n   = cmd_q[2];
  assign cas_n   = cmd_q[1];
  assign we_n    = cmd_q[0];
  assign cke     = cke_q;
  assign busy    = busy_q;
  assign ref_req = req_q;
endmodule

// File: rtl/sdr_refresh_seq_chk.sv
module sdr_refresh_seq_chk #(
  parameter int T_RC  = 8,
  parameter int T_RP  = 3,
  parameter int T_XSR = 10
) (
  input logic clk,
  input logic rst,
  input logic grant,
  input logic banks_idle,
  input logic busy,
  input logic cke,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  localparam int GAP = (T_RC > T_RP) ? T_RC : T_RP;

  logic [2:0] cmd;
  logic       cke_d;
  int         since_ref, since_wake;

  assign cmd = {ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref  <= GAP;
      since_wake <= T_XSR;
      cke_d      <= 1'b1;
    end else begin
      cke_d <= cke;
      if (cmd == 3'b001)          since_ref <= 1;
      else if (since_ref < GAP)   since_ref <= since_ref + 1;
      if (cke && !cke_d)          since_wake <= 1;
      else if (since_wake < T_XSR) since_wake <= since_wake + 1;
    end
  end

  AST_START_GRANTED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(grant && banks_idle)); // R3
  AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cmd != 3'b111) |-> (since_ref >= GAP)); // R4
  AST_CKE_FALL_IS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (cmd == 3'b001)); // R6
  AST_SELF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cke && $past(!cke)) |-> (cmd == 3'b111)); // R7
  AST_EXIT_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    (cmd != 3'b111) |-> (since_wake >= T_XSR)); // R8
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    ((cmd != 3'b111) || !cke) |-> busy); // R9
endmodule

bind sdr_refresh_seq sdr_refresh_seq_chk #(
  .T_RC (T_RC), .T_RP (T_RP), .T_XSR (T_XSR)
) u_chk (
  .clk (clk), .rst (rst), .grant (grant), .banks_idle (banks_idle),
  .busy (busy), .cke (cke), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
);

// File: tb/test_sdr_refresh_seq.sv
module test_sdr_refresh_seq;
  localparam int KHZ  = 50;
  localparam int WIN  = 8;
  localparam int ROWS = 16;
  localparam int TRC  = 6;
  localparam int TRP  = 3;
  localparam int TXSR = 9;
  localparam int PMAX = 4;
  localparam int REFI = KHZ * WIN / ROWS;
  localparam int G    = (TRC > TRP) ? TRC : TRP;

  logic clk = 1'b0, rst = 1'b1;
  logic banks_idle = 1'b0, grant = 1'b0, sr_req = 1'b0, sr_exit = 1'b0;
  logic ref_req, busy, cke, ras_n, cas_n, we_n;

  always #4 clk = ~clk;

  sdr_refresh_seq #(
    .CLK_KHZ(KHZ), .REF_WINDOW_MS(WIN), .REF_ROWS(ROWS),
    .T_RC(TRC), .T_RP(TRP), .T_XSR(TXSR), .PEND_MAX(PMAX)
  ) i_sdr_refresh_seq (
    .clk(clk), .rst(rst), .banks_idle(banks_idle), .grant(grant),
    .sr_req(sr_req), .sr_exit(sr_exit), .ref_req(ref_req), .busy(busy),
    .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int n_chk = 0, n_fail = 0;
  int refs_hi = 0, cke_hi_seen = 0, mon_cyc = 0, rise_at = -1, xsr_meas = -1;
  int wd = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int  m_t, m_pend, m_phase, m_wait, m_left;
  bit  m_post;
  logic [2:0] e_cmd;
  bit  e_cke, e_busy, e_req;

  always @(posedge clk) begin
    bit tick, used;
    int nph;
    if (rst) begin
      m_t = 0; m_pend = 0; m_phase = 0; m_wait = 0; m_left = 0; m_post = 0;
      e_cmd = 3'b111; e_cke = 1; e_busy = 0; e_req = 0;
    end else begin
      tick = (m_t == REFI - 1);
      m_t  = tick ? 0 : m_t + 1;
      e_cmd = 3'b111; used = 0; nph = m_phase;
      if (m_phase == 0) begin
        e_cke = 1;
        if (grant && banks_idle && (sr_req || m_pend > 0)) begin
          e_cmd = 3'b001; m_wait = G - 1;
          if (sr_req) begin nph = 2; m_post = 0; m_left = ROWS - 1; end
          else begin nph = 1; used = 1; end
        end
      end else if (m_phase == 1) begin
        if (m_wait == 0) nph = 0; else m_wait--;
      end else if (m_phase == 2) begin
        if (m_wait > 0) m_wait--;
        else if (m_left > 0) begin e_cmd = 3'b001; m_left--; m_wait = G - 1; end
        else if (!m_post) begin e_cmd = 3'b001; e_cke = 0; nph = 3; end
        else nph = 0;
      end else begin
        if (sr_exit) begin
          e_cke = 1; m_wait = TXSR - 1; m_left = ROWS; m_post = 1; nph = 2;
        end
      end
      if (m_phase >= 2) m_pend = 0;
      else begin
        m_pend = m_pend + (tick ? 1 : 0) - (used ? 1 : 0);
        if (m_pend > PMAX) m_pend = PMAX;
      end
      m_phase = nph;
      e_busy = (nph != 0);
      e_req  = (nph == 0) && (sr_req || m_pend > 0);
    end
    #2;
    chk({ras_n, cas_n, we_n} == e_cmd, "R4", "command", {ras_n, cas_n, we_n}, e_cmd);
    chk(cke == e_cke, "R7", "cke", cke, e_cke);
    chk(busy == e_busy, "R5", "busy", busy, e_busy);
    chk(ref_req == e_req, "R2", "ref_req", ref_req, e_req);
    if ({ras_n, cas_n, we_n} != 3'b111)
      chk(busy, "R9", "busy during command", busy, 1);
    // monitor
    mon_cyc++;
    if (cke && {ras_n, cas_n, we_n} == 3'b001) begin
      refs_hi++;
      if (rise_at >= 0 && xsr_meas < 0) xsr_meas = mon_cyc - rise_at;
    end
    if (cke) cke_hi_seen++;
  end

  logic cke_prev = 1'b1;
  always @(posedge clk) begin
    #3;
    if (cke && !cke_prev) rise_at = mon_cyc;
    cke_prev = cke;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual=%0d expected<=%0d", wd, 100000);
      summary();
      $finish;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cycles(4);
    chk(cke == 1 && busy == 0 && ref_req == 0 && {ras_n, cas_n, we_n} == 3'b111,
        "R1", "reset outputs", {cke, busy, ref_req, ras_n, cas_n, we_n}, 6'b100111);
    rst = 1'b0;
    @(negedge clk);
    chk(cke == 1 && busy == 0 && ref_req == 0, "R1", "first cycle after reset",
        {cke, busy, ref_req}, 3'b100);

    // Normal running: one retention window with the bus always granted
    grant = 1'b1; banks_idle = 1'b1; refs_hi = 0;
    cycles(ROWS * REFI);
    chk(refs_hi >= ROWS - 1 && refs_hi <= ROWS, "R2", "refreshes per window", refs_hi, ROWS);

    // Withhold the grant: credit saturates, request stays up, nothing issued
    grant = 1'b0; refs_hi = 0;
    cycles(8 * REFI);
    chk(refs_hi == 0, "R3", "refresh without grant", refs_hi, 0);
    chk(ref_req == 1, "R2", "request while pending", ref_req, 1);
    grant = 1'b1;
    cycles(PMAX * G + 3);
    chk(refs_hi == PMAX, "R2", "saturated credit drained", refs_hi, PMAX);
    cycles(3 * REFI);

    // Banks not idle: no refresh even with grant
    banks_idle = 1'b0; refs_hi = 0;
    cycles(3 * REFI);
    chk(refs_hi == 0, "R3", "refresh with open banks", refs_hi, 0);
    banks_idle = 1'b1;
    cycles(4 * G);

    // sr_exit while running has no effect
    while (busy) @(negedge clk);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    chk(cke == 1, "R10", "cke after stray exit", cke, 1);
    cycles(2);
    chk(cke == 1 && {ras_n, cas_n, we_n} != 3'b000, "R10", "no wake effect", cke, 1);

    // Self-refresh entry with pre-burst
    while (busy) @(negedge clk);
    sr_req = 1'b1; refs_hi = 0;
    while (cke && wd < 90000) @(negedge clk);
    chk(refs_hi == ROWS, "R6", "burst before entry", refs_hi, ROWS);
    sr_req = 1'b0;

    // Long stay with noise on the controller inputs
    cke_hi_seen = 0;
    for (int i = 0; i < 300; i++) begin
      grant = i[3]; sr_req = i[4]; banks_idle = i[2];
      @(negedge clk);
    end
    grant = 1'b1; banks_idle = 1'b1; sr_req = 1'b0;
    chk(cke_hi_seen == 0, "R7", "cke high cycles in self-refresh", cke_hi_seen, 0);
    chk(busy == 1, "R9", "busy in self-refresh", busy, 1);

    // Exit with recovery and post-burst
    refs_hi = 0; xsr_meas = -1; rise_at = -1;
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    chk(cke == 1, "R8", "cke after exit", cke, 1);
    while (busy && wd < 90000) @(negedge clk);
    chk(xsr_meas == TXSR, "R8", "exit recovery", xsr_meas, TXSR);
    chk(refs_hi == ROWS, "R8", "burst after exit", refs_hi, ROWS);
    chk(ref_req == 0, "R8", "credit cleared after exit", ref_req, 0);
    cycles(2 * REFI);

    finished = 1;
    summary();
    $finish;
  end
endmodule